// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit control words over a three-wire serial link (serial clock, data, frame enable) and holds the most recent valid word in a control register. Its decoded fields drive the rest of a motor-driver controller: power and enable switches for the spindle and actuator stages, start-up aids, slew and timing selections, gain and retract. The link is write-only. All three serial pins are sampled by the fast system clock, so the serial clock is treated as data and never clocks a flop.

A frame opens when the enable goes high and closes when it goes low. Bits are taken on rising edges of the serial clock seen inside the window, most significant bit first. When the window closes, the captured word replaces the register only if at least 16 bits arrived; a short frame leaves the register untouched, and a long frame keeps the final 16 bits. A one-cycle strobe marks each replacement. Holding the active-low power-on reset low clears every field to 0.

Top module: `sctl_port`

## Requirements
- R1: While `por_n` is low, `ctl_word`, every field output and `upd_stb` are 0, and a frame in progress is abandoned.
- R2: A window carrying exactly 16 serial clock rising edges loads `ctl_word` with the bits in arrival order, the first bit landing in bit 15 and the last in bit 0.
- R3: A window carrying fewer than 16 serial clock rising edges leaves `ctl_word` unchanged and raises no `upd_stb`.
- R4: A window carrying more than 16 rising edges loads the last 16 bits received; earlier bits are dropped.
- R5: `upd_stb` is high for exactly one system clock cycle per accepted frame, in the first cycle in which `ctl_word` shows the new value, and within 5 system clock cycles of the enable falling at the pin.
- R6: Serial clock edges while `ser_en` is low change neither `ctl_word` nor the capture state and raise no `upd_stb`.
- R7: Field outputs are taken from `ctl_word` at fixed positions: bit 0 `run_en` (1 = active, 0 = standby), bit 1 `vcm_en`, bit 2 `spin_en`, bit 3 `brake_en`, bit 4 `bemf_sense_en`, bit 5 `var_count_en`, bit 6 `ext_comm_en`, bit 7 `fast_slew_en`, bits 9:8 `comm_time_sel`, bits 11:10 `off_time_sel`, bit 12 `spin_gain_hi`, bit 13 `retract_en`, bits 15:14 `test_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every serial pin |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| ser_clk | input | 1 | Serial bit clock, bit taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame window, active high, at least two system clocks |
| ctl_word | output | 16 | Committed control word |
| upd_stb | output | 1 | One-cycle pulse when a frame is committed |
| run_en | output | 1 | Active (1) or standby (0) |
| vcm_en | output | 1 | Actuator driver enable |
| spin_en | output | 1 | Spindle driver enable |
| brake_en | output | 1 | Spindle brake enable |
| bemf_sense_en | output | 1 | Back-EMF sensing enable |
| var_count_en | output | 1 | Variable count mode for start-up |
| ext_comm_en | output | 1 | External commutation mode |
| fast_slew_en | output | 1 | High commutation slew rate |
| comm_time_sel | output | 2 | Commutation time selection |
| off_time_sel | output | 2 | PWM off-time selection |
| spin_gain_hi | output | 1 | Spindle current loop high gain |
| retract_en | output | 1 | Head retract request |
| test_sel | output | 2 | Factory test selection |

## Verification
On every cycle the assertions watch the capture state: the bit counter never passes 16, nothing moves while the window is closed, a commit request only follows a full count, the register holds unless a commit arrives and then takes exactly the captured word, and the strobe never lasts two cycles. Whether the right bits end up in the right places, that long frames keep the tail rather than the head, that short frames vanish at the pins, and that reset abandons a half-received frame can only be shown by the bench's scenarios, which predict each committed word from the serial stream and compare it with the strobe-qualified outputs and fields.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int unsigned CTL_W = 16;

  // Field layout; position order is the decode contract with the consumers.
  typedef struct packed {
    logic [1:0] test_sel;      // 15:14
    logic       retract_en;    // 13
    logic       spin_gain_hi;  // 12
    logic [1:0] off_time_sel;  // 11:10
    logic [1:0] comm_time_sel; // 9:8
    logic       fast_slew_en;  // 7
    logic       ext_comm_en;   // 6
    logic       var_count_en;  // 5
    logic       bemf_sense_en; // 4
    logic       brake_en;      // 3
    logic       spin_en;       // 2
    logic       vcm_en;        // 1
    logic       run_en;        // 0
  } ctl_fields_t;

  // Saturating increment of the frame-length counter.
  function automatic int unsigned sat_inc(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // A frame is complete once the counter has reached the word width.
  function automatic logic frame_full(int unsigned cur, int unsigned lim);
    return cur >= lim;
  endfunction

  function automatic ctl_fields_t to_fields(logic [CTL_W-1:0] w);
    return ctl_fields_t'(w);
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter
  import sctl_pkg::*;
#(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         dat_s,
  input  logic         en_s,
  output logic         commit_req,
  output logic [W-1:0] cap_word
);

  logic          sclk_q, en_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shift_q;

  // Named events for assertions.
  logic sclk_rise, en_rise, en_fall, take_bit;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign en_rise   = en_s & ~en_q;
  assign en_fall   = ~en_s & en_q;
  assign take_bit  = en_s & ~en_rise & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      en_q       <= 1'b0;
      cnt        <= '0;
      shift_q    <= '0;
      commit_req <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      en_q       <= en_s;
      commit_req <= en_fall & frame_full(32'(cnt), W);
      if (en_rise) begin
        cnt <= '0;
      end else if (take_bit) begin
        cnt     <= CW'(sat_inc(32'(cnt), W));
        shift_q <= {shift_q[W-2:0], dat_s};
      end
    end
  end

  assign cap_word = shift_q;

  a_r4_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= W);
  a_r6_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(cnt) && $stable(shift_q));
  a_r3_commit_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> 32'($past(cnt)) == W);
  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req);

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] cap_word,
  output logic [W-1:0] word,
  output logic         upd_stb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= RESET_VAL;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= commit;
      if (commit) word <= cap_word;
    end
  end

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(word));
  a_r2_loads_capture: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> word == $past(cap_word));
  a_r5_stb_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(commit));

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_en,
  output logic [CTL_W-1:0] ctl_word,
  output logic             upd_stb,
  output logic             run_en,
  output logic             vcm_en,
  output logic             spin_en,
  output logic             brake_en,
  output logic             bemf_sense_en,
  output logic             var_count_en,
  output logic             ext_comm_en,
  output logic             fast_slew_en,
  output logic [1:0]       comm_time_sel,
  output logic [1:0]       off_time_sel,
  output logic             spin_gain_hi,
  output logic             retract_en,
  output logic [1:0]       test_sel
);

  logic [2:0]       pins_s;
  logic             commit_req;
  logic [CTL_W-1:0] cap_word;
  ctl_fields_t      f;

  sctl_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_in  ({ser_en, ser_dat, ser_clk}),
    .d_out (pins_s)
  );

  sctl_shifter #(.W(CTL_W)) u_shift (
    .clk        (clk),
    .rst_n      (por_n),
    .sclk_s     (pins_s[0]),
    .dat_s      (pins_s[1]),
    .en_s       (pins_s[2]),
    .commit_req (commit_req),
    .cap_word   (cap_word)
  );

  sctl_regfile #(.W(CTL_W)) u_reg (
    .clk      (clk),
    .rst_n    (por_n),
    .commit   (commit_req),
    .cap_word (cap_word),
    .word     (ctl_word),
    .upd_stb  (upd_stb)
  );

  assign f             = to_fields(ctl_word);
  assign run_en        = f.run_en;
  assign vcm_en        = f.vcm_en;
  assign spin_en       = f.spin_en;
  assign brake_en      = f.brake_en;
  assign bemf_sense_en = f.bemf_sense_en;
  assign var_count_en  = f.var_count_en;
  assign ext_comm_en   = f.ext_comm_en;
  assign fast_slew_en  = f.fast_slew_en;
  assign comm_time_sel = f.comm_time_sel;
  assign off_time_sel  = f.off_time_sel;
  assign spin_gain_hi  = f.spin_gain_hi;
  assign retract_en    = f.retract_en;
  assign test_sel      = f.test_sel;

  a_r5_stb_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    upd_stb |=> !upd_stb);
  a_r1_reset_clear: assert property (@(posedge clk)
    !por_n |-> (ctl_word == '0) && !upd_stb);

endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic [15:0] ctl_word;
  logic upd_stb, run_en, vcm_en, spin_en, brake_en, bemf_sense_en;
  logic var_count_en, ext_comm_en, fast_slew_en, spin_gain_hi, retract_en;
  logic [1:0] comm_time_sel, off_time_sel, test_sel;

  always #10 clk = ~clk;  // 50 MHz

  sctl_port u_sctl_port (
    .clk(clk), .por_n(por_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .ctl_word(ctl_word), .upd_stb(upd_stb), .run_en(run_en), .vcm_en(vcm_en),
    .spin_en(spin_en), .brake_en(brake_en), .bemf_sense_en(bemf_sense_en),
    .var_count_en(var_count_en), .ext_comm_en(ext_comm_en), .fast_slew_en(fast_slew_en),
    .comm_time_sel(comm_time_sel), .off_time_sel(off_time_sel),
    .spin_gain_hi(spin_gain_hi), .retract_en(retract_en), .test_sel(test_sel)
  );

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_exp = '0;
  int since_fall = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected word on every strobe, checks word, fields, latency.
  always @(negedge clk) begin
    if (ser_en) since_fall <= 0; else since_fall <= since_fall + 1;
    if (upd_stb && por_n) begin
      mchecks++;
      if (exp_q.size() == 0) begin
        merrors++;
        $display("FAIL R3 unexpected strobe actual=%h expected=none", ctl_word);
      end else begin
        logic [15:0] e;
        logic [15:0] fw;
        e = exp_q.pop_front();
        if (ctl_word !== e) begin
          merrors++;
          $display("FAIL R2/R4 word actual=%h expected=%h", ctl_word, e);
        end
        fw = {test_sel, retract_en, spin_gain_hi, off_time_sel, comm_time_sel,
              fast_slew_en, ext_comm_en, var_count_en, bemf_sense_en,
              brake_en, spin_en, vcm_en, run_en};
        mchecks++;
        if (fw !== e) begin
          merrors++;
          $display("FAIL R7 fields actual=%h expected=%h", fw, e);
        end
        mchecks++;
        if (since_fall > 5) begin
          merrors++;
          $display("FAIL R5 latency actual=%0d expected<=5", since_fall);
        end
      end
    end
  end

  // Strobe width watch (R5).
  logic stb_prev = 1'b0;
  always @(negedge clk) begin
    if (stb_prev && upd_stb) begin
      merrors++;
      $display("FAIL R5 strobe width actual=2+ expected=1");
    end
    stb_prev <= upd_stb;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    ser_dat = b; wait_clk(3);
    ser_clk = 1'b1; wait_clk(3);
    ser_clk = 1'b0; wait_clk(2);
  endtask

  // Sends n bits, bits[n-1] first; pushes the expected word when n >= 16.
  task automatic send_frame(input logic [31:0] bits, input int n);
    ser_en = 1'b1; wait_clk(4);
    for (int i = n - 1; i >= 0; i--) pulse_bit(bits[i]);
    if (n >= 16) begin
      exp_q.push_back(bits[15:0]);
      last_exp = bits[15:0];
    end
    wait_clk(2);
    ser_en = 1'b0;
    wait_clk(10);
  endtask

  task automatic settle_check(input string req);
    check(exp_q.size() == 0, req, 32'(exp_q.size()), 0);
    check(ctl_word === last_exp, req, 32'(ctl_word), 32'(last_exp));
  endtask

  initial begin
    wait_clk(5);
    // R1: reset state
    check(ctl_word === 16'h0 && !upd_stb, "R1 reset", 32'(ctl_word), 0);
    check({run_en, vcm_en, spin_en, test_sel} === 5'b0, "R1 fields", 32'({run_en, vcm_en, spin_en, test_sel}), 0);
    por_n = 1'b1; wait_clk(5);

    send_frame(32'h0000_A5C3, 16);         settle_check("R2 exact A5C3");
    send_frame(32'h0000_1234 >> 7, 9);     settle_check("R3 short 9");
    send_frame(32'h000F_5A0F, 20);         settle_check("R4 long 20");
    // R6: serial clocks with enable low
    for (int i = 0; i < 6; i++) pulse_bit(1'b1);
    wait_clk(10);                          settle_check("R6 idle clocks");
    send_frame(32'h0000_7FFF, 15);         settle_check("R3 short 15");
    send_frame(32'h0000_FFFF, 16);         settle_check("R7 all ones");
    send_frame(32'h0000_0001, 16);         settle_check("R7 run bit");
    send_frame(32'h0000_8000, 16);         settle_check("R2 msb first");
    send_frame(32'hDEAD_3C96, 32);         settle_check("R4 long 32");
    send_frame(32'h0000_0000, 1);          settle_check("R3 single bit");

    // R1: reset mid-frame abandons the frame
    ser_en = 1'b1; wait_clk(4);
    for (int i = 0; i < 10; i++) pulse_bit(i[0]);
    por_n = 1'b0; wait_clk(3);
    check(ctl_word === 16'h0 && !upd_stb, "R1 mid-frame reset", 32'(ctl_word), 0);
    last_exp = '0;
    por_n = 1'b1; wait_clk(3);
    for (int i = 0; i < 8; i++) pulse_bit(1'b1);
    ser_en = 1'b0; wait_clk(10);           settle_check("R1 abandoned frame");

    send_frame(32'h0000_2B4D, 16);         settle_check("R2 after reset");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    wait_clk(2);
    $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks);
    $finish;
  end

endmodule